// File: doc/BRIEF.md
# Power Mode Sequencing Controller

A synchronous controller that tracks the operating mode of a camera chip and orders the handshakes between the host and the board that move the chip into and out of its low-power modes. The controller watches two external mode pins, host commands, an input-clock-present flag and a clock-stable flag. It drives a 2-bit mode status, a busy flag, an enable for the core logic, a retention flag for memories and registers, an enable for the host's bypass path to the display, and a request to reload the camera program.

Each low-power entry takes two steps. The host first issues a command. The board then confirms it with a pin code or by removing the clock. A pin code or clock loss that arrives without the matching command has no effect on the mode. It sets a sticky error flag that only the host can clear. The two exits differ. Standby keeps state, so leaving it needs only a stable clock and a resume command. Power-down loses the program, so after its exit the controller asks for a reload and waits for the reload to complete before it reports full operation.

A stabilisation window of `STABLE_CYCLES` clock-present cycles gates every exit, together with the clock-stable flag. A resume command that arrives before the window ends is held pending and acted on when the window closes.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode status is 2'b00 (startup) with busy high. The core enable, retention, bypass enable, reload request and error outputs are all low.
- R2: The controller leaves startup for full operation (mode 2'b01, busy low, core enable high) only once the clock-present count has reached `STABLE_CYCLES` and `clk_stable_i` is high. If either condition is missing, it stays in startup.
- R3: Commands are qualified by `cmd_valid_i`, with `cmd_i` encoded as 2'b00 clear error, 2'b01 power save, 2'b10 power down and 2'b11 resume full operation. Pin codes use the same encoding as the mode status.
- R4: Standby (mode 2'b11) is entered only from the power-save-armed state, which a power-save command sets up. Entry then happens on pin code 2'b11 or on loss of the input clock. While armed, the mode stays 2'b01 with busy high.
- R5: In standby and in its wake state, retention and bypass enable are high and core enable is low.
- R6: Standby is left when the clock is present and the pins are not 2'b11. This starts a fresh stabilisation window (mode stays 2'b11, busy high). A resume command, either present when the window closes or received earlier while waking, returns the chip to full operation.
- R7: Power-down (mode 2'b10, busy low, core enable low) is entered only from the power-down-armed state, which a power-down command sets up, and only on pin code 2'b10.
- R8: Pin code 2'b01 during power-down starts a wake with a fresh stabilisation window. A resume command after the window enters a reloading sub-state: mode 2'b10, busy high, reload request high. Full operation follows only after `reload_done_i` is seen.
- R9: In full operation, pin code 2'b11, pin code 2'b10 or clock loss does not change the mode or the core enable; it sets the sticky error flag. A clear-error command resets the flag.
- R10: Busy is high in startup, in both armed states, in both wake states and during reloading. It is low in full operation, standby and power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_pin_i | input | 2 | External mode pins |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_i | input | 2 | Host command code |
| clk_present_i | input | 1 | Input clock is running |
| clk_stable_i | input | 1 | Clock source reports stability |
| reload_done_i | input | 1 | Camera program reload finished |
| mode_o | output | 2 | Current mode, pin encoding |
| busy_o | output | 1 | Transition handshake in progress |
| core_en_o | output | 1 | Core logic enable |
| retain_o | output | 1 | Memory and register retention |
| bypass_en_o | output | 1 | Host bypass path to display enabled |
| reload_req_o | output | 1 | Program reload requested |
| err_o | output | 1 | Sticky illegal-transition flag |

## Verification
All outputs are decoded directly from the sequencing state, so a wrong state shows at the ports in the cycle after the faulty transition. It appears as a wrong mode code, a busy level that does not match, or an enable pair that contradicts the mode. A wrong stabilisation count or a lost pending command shows up as a resume that completes too early, too late or never. The bench measures these exits against fixed cycle windows. A missing arm check shows up as a mode change on an illegal pin code, and the bench also checks the error flag in that case.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam logic [1:0] MODE_STARTUP = 2'b00;
  localparam logic [1:0] MODE_FULL    = 2'b01;
  localparam logic [1:0] MODE_STANDBY = 2'b11;
  localparam logic [1:0] MODE_PWRDN   = 2'b10;

  localparam logic [1:0] CMD_CLR_ERR = 2'b00;
  localparam logic [1:0] CMD_PSAVE   = 2'b01;
  localparam logic [1:0] CMD_PDOWN   = 2'b10;
  localparam logic [1:0] CMD_RESUME  = 2'b11;

  typedef enum logic [3:0] {
    ST_STARTUP,
    ST_FULL,
    ST_SAVE_ARM,
    ST_STANDBY,
    ST_STBY_WAKE,
    ST_PD_ARM,
    ST_PWRDN,
    ST_PD_WAKE,
    ST_RELOAD
  } pwr_state_e;
endpackage

// File: rtl/pwr_stab_timer.sv
module pwr_stab_timer #(
  parameter int unsigned STABLE_CYCLES = 1024,
  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_present_i,
  input  logic clk_stable_i,
  input  logic restart_i,
  output logic clk_ok_o
);
  localparam logic [CW-1:0] LIMIT = CW'(STABLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!clk_present_i || restart_i) cnt_q <= '0;
    else if (cnt_q != LIMIT)              cnt_q <= cnt_q + 1'b1;
  end

  assign clk_ok_o = (cnt_q == LIMIT) && clk_stable_i && clk_present_i;

  // R2: a full window is kept while the clock stays present
  p_window_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LIMIT && clk_present_i && !restart_i) |=> cnt_q == LIMIT);

  // R2: losing the clock empties the window
  p_window_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_present_i |=> !clk_ok_o);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_pin_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic       clk_present_i,
  input  logic       clk_ok_i,
  input  logic       reload_done_i,
  output pwr_state_e state_o,
  output logic       restart_o,
  output logic       err_o
);
  pwr_state_e state_q, state_d;
  logic pend_q, pend_d, err_q, err_d, illegal;

  logic c_psave, c_pdown, c_resume, c_clr, wake_now, wake_nxt;
  assign c_psave  = cmd_valid_i && cmd_i == CMD_PSAVE;
  assign c_pdown  = cmd_valid_i && cmd_i == CMD_PDOWN;
  assign c_resume = cmd_valid_i && cmd_i == CMD_RESUME;
  assign c_clr    = cmd_valid_i && cmd_i == CMD_CLR_ERR;

  always_comb begin
    state_d = state_q;
    illegal = 1'b0;
    unique case (state_q)
      ST_STARTUP:  if (clk_ok_i) state_d = ST_FULL;
      ST_FULL: begin
        if (c_psave)      state_d = ST_SAVE_ARM;
        else if (c_pdown) state_d = ST_PD_ARM;
        else if (mode_pin_i == MODE_STANDBY || mode_pin_i == MODE_PWRDN || !clk_present_i)
          illegal = 1'b1;
      end
      ST_SAVE_ARM: begin
        if (mode_pin_i == MODE_STANDBY || !clk_present_i) state_d = ST_STANDBY;
        else if (c_resume)                                state_d = ST_FULL;
        else if (mode_pin_i == MODE_PWRDN)                illegal = 1'b1;
      end
      ST_PD_ARM: begin
        if (mode_pin_i == MODE_PWRDN) state_d = ST_PWRDN;
        else if (c_resume)            state_d = ST_FULL;
        else if (mode_pin_i == MODE_STANDBY || !clk_present_i) illegal = 1'b1;
      end
      ST_STANDBY:
        if (clk_present_i && mode_pin_i != MODE_STANDBY) state_d = ST_STBY_WAKE;
      ST_STBY_WAKE: begin
        if (!clk_present_i || mode_pin_i == MODE_STANDBY) state_d = ST_STANDBY;
        else if (clk_ok_i && (c_resume || pend_q))        state_d = ST_FULL;
      end
      ST_PWRDN:    if (mode_pin_i == MODE_FULL) state_d = ST_PD_WAKE;
      ST_PD_WAKE: begin
        if (mode_pin_i == MODE_PWRDN)              state_d = ST_PWRDN;
        else if (clk_ok_i && (c_resume || pend_q)) state_d = ST_RELOAD;
      end
      ST_RELOAD:   if (reload_done_i) state_d = ST_FULL;
      default:     state_d = ST_STARTUP;
    endcase
  end

  assign wake_now  = state_q == ST_STBY_WAKE || state_q == ST_PD_WAKE;
  assign wake_nxt  = state_d == ST_STBY_WAKE || state_d == ST_PD_WAKE;
  assign restart_o = wake_nxt && !wake_now;

  // early resume is remembered until the window closes
  assign pend_d = (wake_now && state_d == state_q) ? (pend_q || c_resume) : 1'b0;
  assign err_d  = illegal ? 1'b1 : (c_clr ? 1'b0 : err_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STARTUP;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      err_q   <= err_d;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;

  // R4, R7: low-power modes are never reached straight from full operation
  p_no_direct_lp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FULL |=> (state_q != ST_STANDBY && state_q != ST_PWRDN));

  // R6: no resume before the window closes
  p_wake_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY_WAKE && !clk_ok_i) |=> state_q != ST_FULL);

  // R8: reload must finish before full operation
  p_reload_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RELOAD && !reload_done_i) |=> state_q == ST_RELOAD);

  // R9: error flag is sticky until cleared
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !c_clr) |=> err_q);
endmodule

// File: rtl/pwr_out_map.sv
module pwr_out_map
  import pwr_mode_pkg::*;
(
  input  pwr_state_e state_i,
  output logic [1:0] mode_o,
  output logic       busy_o,
  output logic       core_en_o,
  output logic       retain_o,
  output logic       bypass_en_o,
  output logic       reload_req_o
);
  always_comb begin
    mode_o       = MODE_STARTUP;
    busy_o       = 1'b0;
    core_en_o    = 1'b0;
    retain_o     = 1'b0;
    bypass_en_o  = 1'b0;
    reload_req_o = 1'b0;
    unique case (state_i)
      ST_STARTUP:  busy_o = 1'b1;
      ST_FULL:     begin mode_o = MODE_FULL; core_en_o = 1'b1; end
      ST_SAVE_ARM, ST_PD_ARM:
        begin mode_o = MODE_FULL; core_en_o = 1'b1; busy_o = 1'b1; end
      ST_STANDBY:  begin mode_o = MODE_STANDBY; retain_o = 1'b1; bypass_en_o = 1'b1; end
      ST_STBY_WAKE:
        begin mode_o = MODE_STANDBY; retain_o = 1'b1; bypass_en_o = 1'b1; busy_o = 1'b1; end
      ST_PWRDN:    mode_o = MODE_PWRDN;
      ST_PD_WAKE:  begin mode_o = MODE_PWRDN; busy_o = 1'b1; end
      ST_RELOAD:   begin mode_o = MODE_PWRDN; busy_o = 1'b1; reload_req_o = 1'b1; end
      default:     busy_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_pin_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic       clk_present_i,
  input  logic       clk_stable_i,
  input  logic       reload_done_i,
  output logic [1:0] mode_o,
  output logic       busy_o,
  output logic       core_en_o,
  output logic       retain_o,
  output logic       bypass_en_o,
  output logic       reload_req_o,
  output logic       err_o
);
  pwr_state_e state;
  logic clk_ok, restart;

  pwr_stab_timer #(.STABLE_CYCLES(STABLE_CYCLES)) u_timer (
    .clk_i, .rst_ni, .clk_present_i, .clk_stable_i,
    .restart_i (restart),
    .clk_ok_o  (clk_ok)
  );

  pwr_mode_fsm u_fsm (
    .clk_i, .rst_ni, .mode_pin_i, .cmd_valid_i, .cmd_i, .clk_present_i,
    .clk_ok_i      (clk_ok),
    .reload_done_i,
    .state_o       (state),
    .restart_o     (restart),
    .err_o
  );

  pwr_out_map u_map (
    .state_i (state),
    .mode_o, .busy_o, .core_en_o, .retain_o, .bypass_en_o, .reload_req_o
  );

  // R5: running, retained and reloading are exclusive
  p_enables_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_en_o, retain_o, reload_req_o}));

  // R7: core is never enabled while reporting power-down
  p_pd_core_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_PWRDN |-> !core_en_o);
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int STAB = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pin = 2'b00, cmd = 2'b00;
  logic cmd_v = 1'b0, clk_pr = 1'b1, clk_st = 1'b0, rl_done = 1'b0;
  logic [1:0] mode;
  logic busy, core_en, retain, byp, rl_req, err;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.STABLE_CYCLES(STAB)) u_pwr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_pin_i(pin), .cmd_valid_i(cmd_v),
    .cmd_i(cmd), .clk_present_i(clk_pr), .clk_stable_i(clk_st),
    .reload_done_i(rl_done), .mode_o(mode), .busy_o(busy),
    .core_en_o(core_en), .retain_o(retain), .bypass_en_o(byp),
    .reload_req_o(rl_req), .err_o(err)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] c);
    cmd = c; cmd_v = 1'b1;
    step(1);
    cmd_v = 1'b0;
  endtask

  // outputs packed {mode,busy,core,retain,byp,reload}
  function automatic int outs();
    return {mode, busy, core_en, retain, byp, rl_req};
  endfunction

  task automatic t_reset;
    chk(outs() == 7'b00_1_0000 && !err, "R1 reset outputs", outs(), 7'b00_1_0000);
  endtask

  task automatic t_startup;
    step(STAB + 8);
    chk(mode == 2'b00, "R2 waits for clk_stable", mode, 0);
    clk_st = 1'b1;
    step(1);
    chk(outs() == 7'b01_0_1000, "R2 full operation after window", outs(), 7'b01_0_1000);
  endtask

  task automatic t_illegal;
    pin = 2'b11; step(1);
    chk(mode == 2'b01 && core_en, "R9 pin 11 without command", mode, 1);
    chk(err, "R9 error set", err, 1);
    pin = 2'b01; step(3);
    chk(err, "R9 error sticky", err, 1);
    send(2'b00);
    chk(!err, "R9 error cleared", err, 0);
    clk_pr = 1'b0; step(1);
    chk(mode == 2'b01 && err, "R9 clock loss without command", {mode, err}, 3'b011);
    clk_pr = 1'b1; pin = 2'b10; step(1);
    chk(mode == 2'b01, "R9 pin 10 without command", mode, 1);
    pin = 2'b01; send(2'b00);
    chk(!err, "R3 clear command", err, 0);
    step(STAB + 2);
  endtask

  task automatic t_standby_pin;
    send(2'b01);
    chk(mode == 2'b01 && busy, "R4 armed keeps full, busy", {mode, busy}, 3'b011);
    chk(busy, "R10 busy while armed", busy, 1);
    pin = 2'b11; step(1);
    chk(outs() == 7'b11_0_0110, "R5 standby outputs", outs(), 7'b11_0_0110);
    pin = 2'b01; step(1);
    chk(mode == 2'b11 && busy, "R6 wake keeps standby, busy", {mode, busy}, 3'b111);
    send(2'b11);
    step(5);
    chk(mode == 2'b11, "R6 early resume waits for window", mode, 3);
    begin
      int k = 0;
      while (mode != 2'b01 && k < 40) begin step(1); k++; end
      chk(mode == 2'b01 && !busy, "R6 pending resume completes", {mode, busy}, 3'b010);
      chk(k >= STAB - 8 && k <= STAB, "R6 resume at window end", k, STAB - 6);
    end
  endtask

  task automatic t_standby_clk;
    send(2'b01);
    clk_pr = 1'b0; step(1);
    chk(mode == 2'b11 && retain, "R4 clock loss enters standby", mode, 3);
    clk_pr = 1'b1; step(STAB + 4);
    chk(mode == 2'b11 && busy, "R6 no resume without command", {mode, busy}, 3'b111);
    send(2'b11);
    chk(outs() == 7'b01_0_1000, "R6 resume after window", outs(), 7'b01_0_1000);
  endtask

  task automatic t_powerdown;
    pin = 2'b10; step(1);
    chk(mode == 2'b01 && err, "R7 pin 10 needs command", mode, 1);
    pin = 2'b01; send(2'b00);
    send(2'b10);
    pin = 2'b10; step(1);
    chk(outs() == 7'b10_0_0000, "R7 power-down outputs", outs(), 7'b10_0_0000);
    pin = 2'b01; step(STAB + 4);
    chk(mode == 2'b10 && busy, "R10 busy in pd wake", {mode, busy}, 3'b101);
    send(2'b11);
    chk(outs() == 7'b10_1_0001, "R8 reloading sub-state", outs(), 7'b10_1_0001);
    step(6);
    chk(rl_req && mode == 2'b10, "R8 waits for reload done", rl_req, 1);
    rl_done = 1'b1; step(1); rl_done = 1'b0;
    chk(outs() == 7'b01_0_1000, "R8 full after reload", outs(), 7'b01_0_1000);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset;
    pin = 2'b01;
    t_startup;
    t_illegal;
    t_standby_pin;
    t_standby_clk;
    t_powerdown;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule